// File: doc/BRIEF.md
# Link Frame Checksum Checker

This block sits after the deserializer of one real-time input link and sees one 128-bit payload word per bunch crossing. Each word carries eight energy samples and a checksum. The block splits out the samples and recomputes the checksum.

When the checksum matches, the samples go downstream one crossing later with their valid strobe high. When it does not match, the samples are still forwarded but the valid strobe stays low, and an error pulse is raised. A saturating error counter advances, and the whole frame is written into a small capture buffer. A control bus drains that buffer one frame at a time. Frames reach the buffer only on a mismatch, so in normal running it stays empty.

Everything runs on the bunch clock, and the datapath has a single register stage.

Top module: `link_frame_checker`

## Requirements
- R1: When `in_valid` is high, `out_samples` in the next cycle equals `in_frame[111:0]`, with sample k at bits 14k+13:14k. This happens whether or not the checksum matches, and `out_samples` holds while `in_valid` is low.
- R2: A frame matches when `in_frame[127:112]` equals the sum, modulo 2^16, of its eight 14-bit samples, each zero-extended to 16 bits.
- R3: `out_valid` is high in the cycle after a matching frame is presented with `in_valid` high, and low in every other cycle.
- R4: `out_err` is high for one cycle, the cycle after a mismatching frame is presented with `in_valid` high. It is never high together with `out_valid`.
- R5: Each mismatch increments `err_count` by one, and the new value is visible in the same cycle as `out_err`.
- R6: `err_count` saturates at its all-ones value.
- R7: An `err_clear` pulse zeroes `err_count` and `cap_overflow` in the next cycle. It wins over a mismatch in the same cycle.
- R8: Mismatching frames enter the capture buffer in arrival order. While `cap_empty` is low, `cap_data` shows the oldest frame. A `cap_rd` pulse removes that frame.
- R9: The buffer holds 8 frames. A mismatching frame that arrives while 8 are held is dropped, even if `cap_rd` is high in the same cycle, and `cap_overflow` is set until cleared.
- R10: While `in_valid` is low, the frame input has no effect on the outputs, the counter or the buffer.
- R11: After reset, `out_valid` and `out_err` are low, `out_samples` and `err_count` are zero, `cap_empty` is high and `cap_overflow` is low.
- R12: A `cap_rd` pulse on an empty buffer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A payload word is present this crossing |
| in_frame | input | 128 | Payload word: eight samples and a checksum |
| out_valid | output | 1 | Forwarded samples are good |
| out_samples | output | 112 | Forwarded samples, sample 0 in the low bits |
| out_err | output | 1 | One-cycle checksum mismatch pulse |
| err_count | output | 16 | Saturating mismatch count |
| err_clear | input | 1 | Clears the counter and the overflow flag |
| cap_rd | input | 1 | Removes the oldest captured frame |
| cap_data | output | 128 | Oldest captured frame |
| cap_empty | output | 1 | Capture buffer holds no frame |
| cap_overflow | output | 1 | A mismatching frame was dropped on a full buffer |

## Verification
Every result is due exactly one clock after its stimulus. The forwarded samples, both strobes, the counter value, the overflow flag and the head of the buffer all change at the same edge that samples the input. The bench drives a crossing, lets one rising edge pass, updates its queue-based model at that edge, and compares every output at the following falling edge, before it drives the next crossing. Because no result takes a second cycle, any extra or missing register stage shows up as a mismatch on the very next comparison.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
   localparam int LFC_SAMPLES   = 8;
   localparam int LFC_SAMPLE_W  = 14;
   localparam int LFC_CSUM_W    = 16;
   localparam int LFC_CAP_DEPTH = 8;
   localparam int LFC_CNT_W     = 16;
endpackage

// File: rtl/lfc_unpack.sv
module lfc_unpack #(
   parameter int N_SAMPLES = lfc_pkg::LFC_SAMPLES,
   parameter int SAMPLE_W  = lfc_pkg::LFC_SAMPLE_W,
   parameter int CSUM_W    = lfc_pkg::LFC_CSUM_W,
   localparam int PAYLOAD_W = N_SAMPLES * SAMPLE_W,
   localparam int FRAME_W   = PAYLOAD_W + CSUM_W
) (
   input  logic [FRAME_W-1:0]   frame,
   output logic [PAYLOAD_W-1:0] samples,
   output logic                 match
);
   logic [CSUM_W-1:0] part [N_SAMPLES+1];

   assign part[0] = '0;
   // one adder per sample, chained; modulo 2^CSUM_W by truncation
   for (genvar k = 0; k < N_SAMPLES; k++) begin : g_acc
      assign part[k+1] = part[k] + CSUM_W'(frame[k*SAMPLE_W +: SAMPLE_W]);
   end

   assign samples = frame[PAYLOAD_W-1:0];
   assign match   = (part[N_SAMPLES] == frame[FRAME_W-1:PAYLOAD_W]);
endmodule

// File: rtl/lfc_sat_counter.sv
module lfc_sat_counter #(
   parameter int W = lfc_pkg::LFC_CNT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 value <= '0;
      else if (clr)               value <= '0;
      else if (inc && value != '1) value <= value + 1'b1;
   end
endmodule

// File: rtl/lfc_capture_buf.sv
module lfc_capture_buf #(
   parameter int DEPTH = lfc_pkg::LFC_CAP_DEPTH,
   parameter int W     = 128,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         ovf_clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         overflow
);
   logic [W-1:0]   mem [DEPTH];
   logic [PTR_W:0] wr_ptr, rd_ptr;
   logic           full, do_push, do_pop;

   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                    (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr[PTR_W-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr[PTR_W-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (ovf_clr)          overflow <= 1'b0;
         else if (push && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/link_frame_checker.sv
module link_frame_checker #(
   parameter int N_SAMPLES = lfc_pkg::LFC_SAMPLES,
   parameter int SAMPLE_W  = lfc_pkg::LFC_SAMPLE_W,
   parameter int CSUM_W    = lfc_pkg::LFC_CSUM_W,
   parameter int CAP_DEPTH = lfc_pkg::LFC_CAP_DEPTH,
   parameter int CNT_W     = lfc_pkg::LFC_CNT_W,
   localparam int PAYLOAD_W = N_SAMPLES * SAMPLE_W,
   localparam int FRAME_W   = PAYLOAD_W + CSUM_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [FRAME_W-1:0]   in_frame,
   output logic                 out_valid,
   output logic [PAYLOAD_W-1:0] out_samples,
   output logic                 out_err,
   output logic [CNT_W-1:0]     err_count,
   input  logic                 err_clear,
   input  logic                 cap_rd,
   output logic [FRAME_W-1:0]   cap_data,
   output logic                 cap_empty,
   output logic                 cap_overflow
);
   if (SAMPLE_W > CSUM_W) begin : g_bad_width
      $error("sample width must not exceed checksum width");
   end
   if (CAP_DEPTH < 2 || (CAP_DEPTH & (CAP_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("capture depth must be a power of two, at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("counter width must be positive");
   end

   logic [PAYLOAD_W-1:0] unpacked;
   logic                 sum_ok, bad_frame;

   lfc_unpack #(
      .N_SAMPLES(N_SAMPLES), .SAMPLE_W(SAMPLE_W), .CSUM_W(CSUM_W)
   ) u_unpack (
      .frame(in_frame), .samples(unpacked), .match(sum_ok)
   );

   assign bad_frame = in_valid && !sum_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_err     <= 1'b0;
         out_samples <= '0;
      end else begin
         out_valid <= in_valid && sum_ok;
         out_err   <= bad_frame;
         if (in_valid) out_samples <= unpacked;
      end
   end

   lfc_sat_counter #(.W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .inc(bad_frame), .clr(err_clear), .value(err_count)
   );

   lfc_capture_buf #(.DEPTH(CAP_DEPTH), .W(FRAME_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .push(bad_frame), .pop(cap_rd), .ovf_clr(err_clear),
      .wdata(in_frame), .rdata(cap_data), .empty(cap_empty), .overflow(cap_overflow)
   );
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
   parameter int CNT_W = lfc_pkg::LFC_CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             err_clear,
   input logic             out_valid,
   input logic             out_err,
   input logic [CNT_W-1:0] err_count,
   input logic             cap_empty,
   input logic             cap_overflow
);
   assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err));

   assert_valid_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> $past(in_valid));

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_err && !$past(err_clear) && $past(err_count) != '1)
         |-> err_count == $past(err_count) + 1'b1);

   assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(err_count) == '1 && !$past(err_clear)) |-> err_count == '1);

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_clear) |-> (err_count == '0 && !cap_overflow));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(in_valid) && !$past(err_clear))
         |-> ($stable(err_count) && !out_valid && !out_err));

   assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_empty) |-> out_err);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_overflow) |-> out_err);
endmodule

bind link_frame_checker lfc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .err_clear(err_clear),
   .out_valid(out_valid), .out_err(out_err), .err_count(err_count),
   .cap_empty(cap_empty), .cap_overflow(cap_overflow)
);

// File: tb/link_frame_checker_tb.sv
`timescale 1ns/1ps
module link_frame_checker_tb;
   localparam int CW  = 4;              // small counter so saturation is reachable
   localparam int MAX = (1 << CW) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_frame = '0;
   logic         err_clear = 1'b0;
   logic         cap_rd = 1'b0;
   logic         out_valid, out_err, cap_empty, cap_overflow;
   logic [111:0] out_samples;
   logic [CW-1:0] err_count;
   logic [127:0] cap_data;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   link_frame_checker #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
      .out_valid(out_valid), .out_samples(out_samples), .out_err(out_err),
      .err_count(err_count), .err_clear(err_clear), .cap_rd(cap_rd),
      .cap_data(cap_data), .cap_empty(cap_empty), .cap_overflow(cap_overflow)
   );

   // reference model state
   logic [127:0] q[$];
   int           m_cnt = 0;
   bit           m_ovf = 0, m_valid = 0, m_err = 0;
   logic [111:0] m_samples = '0;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R2: checksum = sum mod 2^16 of the eight zero-extended 14-bit samples
   function automatic bit sum_ok(input logic [127:0] f);
      int s = 0;
      for (int k = 0; k < 8; k++) s += int'(f[k*14 +: 14]);
      return f[127:112] == 16'(s);
   endfunction

   function automatic logic [127:0] mk(input int mode, input bit bad);
      logic [127:0] f = '0;
      int s = 0;
      for (int k = 0; k < 8; k++) begin
         logic [13:0] v;
         case (mode)
            0: v = '0;
            1: v = 14'h3fff;
            2: v = 14'(k * 1111 + 7);
            default: v = 14'($urandom);
         endcase
         f[k*14 +: 14] = v;
         s += int'(v);
      end
      f[127:112] = 16'(s) ^ (bad ? 16'h0001 : 16'h0000);
      return f;
   endfunction

   task automatic compare_all();
      chk(out_valid == m_valid, "R3 out_valid", 128'(out_valid), 128'(m_valid));
      chk(out_err == m_err, "R4 out_err", 128'(out_err), 128'(m_err));
      chk(out_samples == m_samples, "R1 out_samples", 128'(out_samples), 128'(m_samples));
      chk(int'(err_count) == m_cnt, "R5 err_count", 128'(err_count), 128'(m_cnt));
      chk(cap_overflow == m_ovf, "R9 cap_overflow", 128'(cap_overflow), 128'(m_ovf));
      chk(cap_empty == (q.size() == 0), "R8 cap_empty", 128'(cap_empty),
          128'(q.size() == 0));
      if (q.size() > 0) chk(cap_data == q[0], "R8 cap_data", cap_data, q[0]);
   endtask

   task automatic step(input bit v, input logic [127:0] f, input bit clr, input bit rd);
      bit full, bad;
      in_valid = v; in_frame = f; err_clear = clr; cap_rd = rd;
      @(posedge clk);
      bad  = v && !sum_ok(f);
      full = (q.size() == 8);
      m_valid = v && !bad;
      m_err   = bad;
      if (v) m_samples = f[111:0];
      if (rd && q.size() > 0) void'(q.pop_front());
      if (bad && !full) q.push_back(f);
      if (clr) begin m_cnt = 0; m_ovf = 0; end
      else if (bad) begin
         if (m_cnt < MAX) m_cnt++;
         if (full) m_ovf = 1;
      end
      @(negedge clk);
      compare_all();
      in_valid = 0; err_clear = 0; cap_rd = 0;
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk(!out_valid && !out_err && out_samples == '0, "R11 outputs", 128'(out_valid), 0);
      chk(err_count == '0 && cap_empty && !cap_overflow, "R11 status",
          128'(err_count), 0);

      // R1 R2 R3: good frames of several patterns, including checksum wrap (mode 1)
      for (int m = 0; m < 4; m++) step(1, mk(m, 0), 0, 0);
      for (int i = 0; i < 6; i++) step(1, mk(3, 0), 0, 0);
      chk(out_valid == 1'b1, "R2 wrapped checksum accepted", 128'(out_valid), 1);

      // R10: idle cycles with corrupt data on the bus
      step(0, mk(3, 1), 0, 0);
      step(0, mk(2, 1), 0, 0);
      chk(err_count == '0 && cap_empty, "R10 idle frame ignored", 128'(err_count), 0);

      // R12: read on empty buffer
      step(0, '0, 0, 1);
      chk(cap_empty == 1'b1, "R12 empty read", 128'(cap_empty), 1);

      // R4 R8: bad frames mixed with good, then drain
      step(1, mk(2, 1), 0, 0);
      step(1, mk(3, 0), 0, 0);
      step(1, mk(3, 1), 0, 0);
      step(0, '0, 0, 1);
      step(0, '0, 0, 1);

      // R9: fill past capacity, then read while full together with a new bad frame
      for (int i = 0; i < 10; i++) step(1, mk(3, 1), 0, 0);
      chk(cap_overflow == 1'b1, "R9 overflow set", 128'(cap_overflow), 1);
      step(1, mk(3, 1), 0, 1);
      for (int i = 0; i < 8; i++) step(0, '0, 0, 1);
      chk(cap_empty == 1'b1, "R9 only 7 left after drop", 128'(cap_empty), 1);

      // R6: counter saturation
      for (int i = 0; i < MAX + 4; i++) step(1, mk(3, 1), 0, 1);
      chk(err_count == CW'(MAX), "R6 saturated", 128'(err_count), 128'(MAX));

      // R7: clear wins over a simultaneous mismatch
      step(1, mk(3, 1), 1, 0);
      chk(err_count == '0 && !cap_overflow, "R7 clear priority", 128'(err_count), 0);
      step(1, mk(1, 1), 0, 0);
      step(1, mk(0, 0), 0, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule